// File: doc/BRIEF.md
# Addressing-Mode Operand Resolver

This block turns one instruction operand into the value that an accumulator would load. A request has a 3-bit mode and an operand field. The block works out the effective address under the chosen addressing mode and then makes zero, one or two dependent reads from its own word memory. When the value is ready, it drives a one-cycle `done` strobe and holds the value on `result`.

The block reads from a small internal register file. It also takes the current index, base and stack-pointer values as inputs from the surrounding core. The memory and the register file each have a plain write port, which is used to fill them. The memory has a one-cycle synchronous read, so modes that make more reads take longer. The block takes a new request only while `busy` is low.

Top module: `opnd_resolver`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` and `busy` are low and `result` is zero.
- R2: Immediate mode (code 0) returns the operand field zero-extended to DATA_W. `done` rises in the cycle after the request is accepted, and `busy` never goes high.
- R3: Register mode (code 2) returns the register file entry selected by the low REG_AW bits of the operand field. `done` comes one cycle after acceptance.
- R4: Direct mode (code 1) returns the memory word at the operand field. `done` comes two cycles after acceptance.
- R5: Indirect mode (code 3) reads the word at the operand field and uses its low ADDR_W bits as the data address. It returns the word found there. `done` comes three cycles after acceptance.
- R6: Register-indirect mode (code 4) uses the low ADDR_W bits of the selected register as the data address. `done` comes two cycles after acceptance.
- R7: Indexed mode (code 5) reads memory at (operand field + index) modulo 2^ADDR_W. `done` comes two cycles after acceptance.
- R8: Based mode (code 6) reads memory at (base + operand field) modulo 2^ADDR_W. `done` comes two cycles after acceptance.
- R9: Stack mode (code 7) returns the memory word at the stack pointer. The operand field has no effect. `done` comes two cycles after acceptance.
- R10: A request is accepted only when `busy` is low. A request raised while `busy` is high produces no `done` and does not change the value returned.
- R11: `result` changes only in a cycle where `done` is high. `done` is low in the cycle after a done cycle unless a new request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_mode | input | 3 | Addressing mode code |
| req_field | input | ADDR_W | Operand field |
| idx_val | input | ADDR_W | Index register value |
| base_val | input | ADDR_W | Base register value |
| sp_val | input | ADDR_W | Stack pointer value |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | REG_AW | Register file write index |
| rf_wdata | input | DATA_W | Register file write data |
| mem_we | input | 1 | Word memory write enable |
| mem_waddr | input | ADDR_W | Word memory write address |
| mem_wdata | input | DATA_W | Word memory write data |
| busy | output | 1 | A memory read sequence is in progress |
| done | output | 1 | One-cycle strobe: result is valid |
| result | output | DATA_W | Resolved operand value |

## Verification
A request sampled at an edge gives its result one, two or three edges later, according to how many reads the mode needs. Immediate and register modes take one edge. Single-read modes take two edges, and indirect mode takes three.

Each scenario task counts falling edges from acceptance until `done` is seen. It compares that count with the latency expected for the mode, and it checks the value in that same half cycle. On the next falling edge it checks that the strobe has dropped and that `result` has held. The table contents are chosen so that address wrap-around, ignored pointer high bits and an ignored operand field in stack mode each give a value distinct from the wrong answer.

// File: rtl/opr_pkg.sv
package opr_pkg;

  typedef enum logic [2:0] {
    MODE_IMM  = 3'd0,
    MODE_DIR  = 3'd1,
    MODE_REG  = 3'd2,
    MODE_IND  = 3'd3,
    MODE_RIND = 3'd4,
    MODE_IDX  = 3'd5,
    MODE_BASE = 3'd6,
    MODE_STK  = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_DATA = 2'd2
  } rstate_e;

  // number of dependent memory reads a mode needs
  function automatic logic [1:0] reads_for(input mode_e m);
    case (m)
      MODE_IMM, MODE_REG: reads_for = 2'd0;
      MODE_IND:           reads_for = 2'd2;
      default:            reads_for = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/opr_word_mem.sv
module opr_word_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/opr_reg_file.sv
module opr_reg_file #(
  parameter int DATA_W = 16,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int NREG = 1 << REG_AW;

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/opr_ea_unit.sv
module opr_ea_unit
  import opr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] field,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] sp_val,
  output logic [ADDR_W-1:0] ea,
  output logic [1:0]        nreads,
  output logic [DATA_W-1:0] local_val
);
  localparam int PAD_W = DATA_W - ADDR_W;

  always_comb begin
    nreads = reads_for(mode);
    case (mode)
      MODE_RIND: ea = rf_data[ADDR_W-1:0];
      MODE_IDX:  ea = field + idx_val;
      MODE_BASE: ea = base_val + field;
      MODE_STK:  ea = sp_val;
      default:   ea = field;
    endcase
    if (mode == MODE_REG) local_val = rf_data;
    else                  local_val = {{PAD_W{1'b0}}, field};
  end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [ADDR_W-1:0] req_field,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] sp_val,
  input  logic              rf_we,
  input  logic [REG_AW-1:0] rf_waddr,
  input  logic [DATA_W-1:0] rf_wdata,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  rstate_e           state_q;
  mode_e             mode;
  logic              accept;
  logic [DATA_W-1:0] rf_rdata;
  logic [ADDR_W-1:0] ea;
  logic [1:0]        nreads;
  logic [DATA_W-1:0] local_val;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  assign mode   = mode_e'(req_mode);
  assign accept = req_valid && (state_q == ST_IDLE);
  assign busy   = (state_q != ST_IDLE);

  opr_reg_file #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(req_field[REG_AW-1:0]), .rdata(rf_rdata)
  );

  opr_ea_unit #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ea (
    .mode(mode), .field(req_field), .rf_data(rf_rdata), .idx_val(idx_val),
    .base_val(base_val), .sp_val(sp_val), .ea(ea), .nreads(nreads),
    .local_val(local_val)
  );

  // second read of an indirect chain takes its address from the first word
  assign rd_addr = (state_q == ST_PTR) ? rd_data[ADDR_W-1:0] : ea;
  assign rd_en   = (accept && nreads != 2'd0) || (state_q == ST_PTR);

  opr_word_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_en), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            case (nreads)
              2'd0: begin
                result <= local_val;
                done   <= 1'b1;
              end
              2'd2:    state_q <= ST_PTR;
              default: state_q <= ST_DATA;
            endcase
          end
        end
        ST_PTR:  state_q <= ST_DATA;
        ST_DATA: begin
          result  <= rd_data;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

module opnd_resolver_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_mode,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!done && !busy));

  // R2
  fast_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && (req_mode == 3'd0 || req_mode == 3'd2)) |=> (done && !busy));

  // R4
  read_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_mode != 3'd0 && req_mode != 3'd2) |=> (busy && !done));

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy || req_valid));

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind opnd_resolver opnd_resolver_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
  .busy(busy), .done(done), .result(result)
);

// File: tb/test_opnd_resolver.sv
module test_opnd_resolver;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 10;
  localparam int REG_AW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [2:0]        req_mode = '0;
  logic [ADDR_W-1:0] req_field = '0;
  logic [ADDR_W-1:0] idx_val = '0;
  logic [ADDR_W-1:0] base_val = '0;
  logic [ADDR_W-1:0] sp_val = '0;
  logic              rf_we = 1'b0;
  logic [REG_AW-1:0] rf_waddr = '0;
  logic [DATA_W-1:0] rf_wdata = '0;
  logic              mem_we = 1'b0;
  logic [ADDR_W-1:0] mem_waddr = '0;
  logic [DATA_W-1:0] mem_wdata = '0;
  logic              busy, done;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  opnd_resolver #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_opnd_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_field(req_field), .idx_val(idx_val), .base_val(base_val), .sp_val(sp_val),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .busy(busy), .done(done), .result(result)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic mem_put(input int a, input int d);
    @(negedge clk);
    mem_we = 1'b1; mem_waddr = ADDR_W'(a); mem_wdata = DATA_W'(d);
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic rf_put(input int a, input int d);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = REG_AW'(a); rf_wdata = DATA_W'(d);
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  // issue one request, optionally poke a second one while busy,
  // then check latency, value, strobe drop and hold
  task automatic run(input string req, input int mode, input int field,
                     input int exp_lat, input int exp_val, input bit poke);
    int lat;
    int held;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'(mode); req_field = ADDR_W'(field);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (poke && busy) begin
      req_valid = 1'b1; req_mode = 3'd0; req_field = 10'h3C3;
    end
    while (!done && lat < 10) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end
    check(lat == exp_lat, {req, " latency"}, lat, exp_lat);
    check(result == DATA_W'(exp_val), {req, " value"}, int'(result), exp_val);
    held = int'(result);
    @(negedge clk);
    check(!done, {req, " R11 strobe drop"}, int'(done), 0);
    check(result == DATA_W'(held), {req, " R11 hold"}, int'(result), held);
  endtask

  task automatic t_reset;
    check(!done && !busy, "R1 flags", {30'd0, done, busy}, 0);
    check(result == '0, "R1 result", int'(result), 0);
  endtask

  task automatic t_immediate;
    run("R2 imm", 0, 'h2AB, 1, 'h02AB, 1'b0);
    run("R2 imm zero", 0, 'h000, 1, 'h0000, 1'b0);
  endtask

  task automatic t_register;
    rf_put(5, 'h1357);
    run("R3 reg", 2, 'h005, 1, 'h1357, 1'b0);
    run("R3 reg high bits", 2, 'h015, 1, 'h1357, 1'b0);
  endtask

  task automatic t_direct;
    mem_put('h0A0, 'hC0DE);
    run("R4 direct", 1, 'h0A0, 2, 'hC0DE, 1'b0);
  endtask

  task automatic t_indirect;
    mem_put('h050, 'h0123);
    mem_put('h123, 'hBEEF);
    run("R5 indirect", 3, 'h050, 3, 'hBEEF, 1'b0);
    mem_put('h051, 'hFC07);
    mem_put('h007, 'h5A5A);
    run("R5 indirect ptr high bits", 3, 'h051, 3, 'h5A5A, 1'b0);
  endtask

  task automatic t_reg_indirect;
    rf_put(9, 'hF040);
    mem_put('h040, 'h7777);
    run("R6 reg indirect", 4, 'h009, 2, 'h7777, 1'b0);
  endtask

  task automatic t_indexed;
    idx_val = 10'h3F0;
    mem_put('h010, 'h1111);
    mem_put('h3F5, 'h2222);
    run("R7 indexed wrap", 5, 'h020, 2, 'h1111, 1'b0);
    run("R7 indexed", 5, 'h005, 2, 'h2222, 1'b0);
  endtask

  task automatic t_based;
    base_val = 10'h3FF;
    mem_put('h001, 'h3333);
    run("R8 based wrap", 6, 'h002, 2, 'h3333, 1'b0);
  endtask

  task automatic t_stack;
    sp_val = 10'h200;
    mem_put('h200, 'h4444);
    mem_put('h0A1, 'h9999);
    run("R9 stack", 7, 'h0A1, 2, 'h4444, 1'b0);
    run("R9 stack other field", 7, 'h3C3, 2, 'h4444, 1'b0);
  endtask

  task automatic t_busy_ignore;
    run("R10 busy ignore", 3, 'h050, 3, 'hBEEF, 1'b1);
    repeat (2) begin
      @(negedge clk);
      check(!done, "R10 no extra done", int'(done), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_immediate;
    t_register;
    t_direct;
    t_indirect;
    t_reg_indirect;
    t_indexed;
    t_based;
    t_stack;
    t_busy_ignore;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule